// File: doc/BRIEF.md
# Configurable-Width GPIO Port with Register Bank

This block is a single general-purpose I/O port of up to eight pins, programmed through a byte-wide configuration register port. A port enable, a direction register, a data latch and a per-pin polarity-inversion register set how each pin behaves. The choice between push-pull and open-drain output sits in one bit of a chip-wide global register that this port shares with its neighbours. Each pin has an output value, an output enable and an input value. The input value passes through a synchronizer before software reads it.

The port-local registers answer only while `dev_sel` shows that this port's logical device is selected. The global register answers whatever the device selection is. The port drives only its own bit of the shared enable register and its own bit of the global register, and returns zero in every other bit, so that a surrounding decoder can OR the read data of all ports together.

A parameter sets how many pins are implemented. Register bits that have no pin behind them read as zero and are never stored. The surrounding decoder gives the port its address map and the positions of its bits.

Top module: `gpio_bank_port`

## Requirements
- R1: After reset every pin is an input, the data latch and the inversion register are zero, the port is disabled and the output mode is open drain, so every output enable is low.
- R2: While `dev_sel` is 1, the direction register is at `BANK_ADDR`, the data register at `BANK_ADDR+1`, the inversion register at `BANK_ADDR+2`, and the port enable is bit `EN_BIT` of `ENABLE_ADDR`. While `dev_sel` is 0 these registers ignore writes and read as 0.
- R3: The output-mode bit is bit `PP_BIT` of `GLOBAL_ADDR` and can be reached whatever `dev_sel` is. A 1 selects push-pull and a 0 selects open drain. Every other bit of that register reads 0 and ignores writes.
- R4: A direction bit of 1 makes its pin an input and never asserts its output enable. A direction bit of 0 makes the pin an output.
- R5: While the port is disabled every output enable is 0, whatever the direction register holds.
- R6: In push-pull mode, an output pin of an enabled port has its output enable at 1 and drives the data-latch bit XOR the inversion bit.
- R7: In open-drain mode every output value is 0. The output enable of an output pin is 1 only when its data-latch bit XOR its inversion bit is 0.
- R8: A read of the data register returns, for each input pin, the synchronized pin level XOR the inversion bit, and for each output pin, the data-latch bit.
- R9: A change of an input pin appears in the data register read after exactly `SYNC_STAGES` rising clock edges.
- R10: Register bits at or above `NUM_PINS` read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_sel | input | 1 | This port's logical device is selected |
| reg_addr | input | 8 | Configuration register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, captured on the rising edge |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Output value for each pin |
| pin_oe | output | NUM_PINS | Output enable for each pin |

## Verification
The bench builds a five-pin port. For each of the four combinations of enable and output mode, it steps the direction register through all 32 values. Each step pairs a direction value with data, inversion and pin-input patterns derived from it. Because the patterns differ, swapping the latch and the inverted level, dropping the inversion, or gating on the wrong register shows up as a wrong pin value or a wrong read value.

Separate checks cover further cases. Writes with the device deselected are tested, along with global-register access while deselected. All-ones writes probe the unbacked upper bits. A single input edge, timed edge by edge, confirms the synchronizer depth.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and types for the banked GPIO port.
// Assumes byte-wide configuration registers.
package gpio_bank_pkg;
    localparam int REG_W = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN,
        SEL_DIR,
        SEL_DATA,
        SEL_INV,
        SEL_GLB
    } reg_sel_e;
endpackage

// File: rtl/gpio_bank_sync.sv
// Multi-flop synchronizer for the pin inputs.
// Assumes STAGES >= 1. The reset value is 0.
module gpio_bank_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // shift the pin levels one stage further
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
// Address decode, configuration registers and read-back mux for one port.
// Assumes NUM_PINS <= REG_W. Bits at or above NUM_PINS are not stored.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int          NUM_PINS    = 8,
    parameter logic [7:0]  ENABLE_ADDR = 8'h30,
    parameter int          EN_BIT      = 0,
    parameter logic [7:0]  BANK_ADDR   = 8'hE0,
    parameter logic [7:0]  GLOBAL_ADDR = 8'h2B,
    parameter int          PP_BIT      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dev_sel,
    input  logic [7:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                reg_we,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                en_q,
    output logic                pp_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] data_q,
    output logic [NUM_PINS-1:0] inv_q
);
    localparam logic [7:0] DATA_ADDR = BANK_ADDR + 8'd1;
    localparam logic [7:0] INV_ADDR  = BANK_ADDR + 8'd2;

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] wpins;
    logic [NUM_PINS-1:0] data_view;

    assign wpins = reg_wdata[NUM_PINS-1:0];

    // decode the address; the global register ignores device selection
    always_comb begin
        sel = SEL_NONE;
        if (reg_addr == GLOBAL_ADDR)     sel = SEL_GLB;
        else if (dev_sel) begin
            if (reg_addr == ENABLE_ADDR) sel = SEL_EN;
            else if (reg_addr == BANK_ADDR) sel = SEL_DIR;
            else if (reg_addr == DATA_ADDR) sel = SEL_DATA;
            else if (reg_addr == INV_ADDR)  sel = SEL_INV;
        end
    end

    // register writes and reset state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pp_q   <= 1'b0;
            dir_q  <= '1;
            data_q <= '0;
            inv_q  <= '0;
        end else if (reg_we) begin
            case (sel)
                SEL_EN:   en_q   <= reg_wdata[EN_BIT];
                SEL_GLB:  pp_q   <= reg_wdata[PP_BIT];
                SEL_DIR:  dir_q  <= wpins;
                SEL_DATA: data_q <= wpins;
                SEL_INV:  inv_q  <= wpins;
                default: ;
            endcase
        end
    end

    // data read: inputs show the corrected pin level, outputs the latch
    assign data_view = (dir_q & (pin_sync ^ inv_q)) | (~dir_q & data_q);

    // read-back mux, zero outside this port's bits
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_EN:   reg_rdata[EN_BIT] = en_q;
            SEL_GLB:  reg_rdata[PP_BIT] = pp_q;
            SEL_DIR:  reg_rdata = REG_W'(dir_q);
            SEL_DATA: reg_rdata = REG_W'(data_view);
            SEL_INV:  reg_rdata = REG_W'(inv_q);
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_bank_drive.sv
// Per-pin output driver control: push-pull or open-drain, gated by the enable.
// Assumes the inversion applies to the driven level.
module gpio_bank_drive #(
    parameter int NUM_PINS = 8
) (
    input  logic                en,
    input  logic                pp,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] data,
    input  logic [NUM_PINS-1:0] inv,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    genvar i;
    generate
        for (i = 0; i < NUM_PINS; i++) begin : g_pin
            logic level;
            logic drives;
            // level the pin should present and whether it is an active output
            always_comb begin
                level  = data[i] ^ inv[i];
                drives = en & ~dir[i];
                pin_out[i] = pp ? level  : 1'b0;
                pin_oe[i]  = pp ? drives : (drives & ~level);
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_bank_port.sv
// Top of one banked GPIO port: synchronizer, register bank and pin drivers.
// Assumes the decoder ORs this port's read data with its neighbours'.
module gpio_bank_port
    import gpio_bank_pkg::*;
#(
    parameter int          NUM_PINS    = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  ENABLE_ADDR = 8'h30,
    parameter int          EN_BIT      = 0,
    parameter logic [7:0]  BANK_ADDR   = 8'hE0,
    parameter logic [7:0]  GLOBAL_ADDR = 8'h2B,
    parameter int          PP_BIT      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dev_sel,
    input  logic [7:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic                reg_we,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);
    logic                en_q;
    logic                pp_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] inv_q;
    logic [NUM_PINS-1:0] pin_sync;

    gpio_bank_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_bank_regs #(
        .NUM_PINS(NUM_PINS), .ENABLE_ADDR(ENABLE_ADDR), .EN_BIT(EN_BIT),
        .BANK_ADDR(BANK_ADDR), .GLOBAL_ADDR(GLOBAL_ADDR), .PP_BIT(PP_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .pin_sync(pin_sync),
        .reg_rdata(reg_rdata), .en_q(en_q), .pp_q(pp_q), .dir_q(dir_q),
        .data_q(data_q), .inv_q(inv_q)
    );

    gpio_bank_drive #(.NUM_PINS(NUM_PINS)) u_drive (
        .en(en_q), .pp(pp_q), .dir(dir_q), .data(data_q), .inv(inv_q),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/gpio_bank_port_chk.sv
// Assertion checker for gpio_bank_port, bound to every instance.
// Assumes the synchronous active-low reset of the top.
module gpio_bank_port_chk #(
    parameter int         NUM_PINS    = 8,
    parameter logic [7:0] GLOBAL_ADDR = 8'h2B,
    parameter int         PP_BIT      = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dev_sel,
    input logic [7:0]          reg_addr,
    input logic [7:0]          reg_wdata,
    input logic                reg_we,
    input logic                en_q,
    input logic                pp_q,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] data_q,
    input logic [NUM_PINS-1:0] inv_q,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '1 && data_q == '0 && inv_q == '0 && !en_q && !pp_q && pin_oe == '0));

    // R2
    deselected_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !dev_sel && reg_addr != GLOBAL_ADDR)
        |=> ($stable(dir_q) && $stable(data_q) && $stable(inv_q) && $stable(en_q)));

    // R3
    global_bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == GLOBAL_ADDR) |=> (pp_q == $past(reg_wdata[PP_BIT])));

    // R4
    input_never_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & dir_q) == '0);

    // R5
    disabled_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> pin_oe == '0);

    // R6
    push_pull_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp_q |-> pin_out == (data_q ^ inv_q));

    // R7
    open_drain_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pp_q |-> (pin_out == '0 && (pin_oe & (data_q ^ inv_q)) == '0));
endmodule

bind gpio_bank_port gpio_bank_port_chk #(
    .NUM_PINS(NUM_PINS), .GLOBAL_ADDR(GLOBAL_ADDR), .PP_BIT(PP_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .en_q(en_q), .pp_q(pp_q),
    .dir_q(dir_q), .data_q(data_q), .inv_q(inv_q), .pin_out(pin_out),
    .pin_oe(pin_oe)
);

// File: tb/tb_gpio_bank_port.sv
// Self-checking bench: five-pin port, near-exhaustive sweep of the modes.
module tb_gpio_bank_port;
    localparam int         NP     = 5;
    localparam logic [7:0] A_EN   = 8'h30;
    localparam logic [7:0] A_DIR  = 8'hE0;
    localparam logic [7:0] A_DAT  = 8'hE1;
    localparam logic [7:0] A_INV  = 8'hE2;
    localparam logic [7:0] A_GLB  = 8'h2B;
    localparam logic [7:0] MASK   = 8'h1F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dev_sel = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank_port #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        dev_sel = sel; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        dev_sel = sel; reg_addr = a; reg_we = 1'b0;
        #1 d = reg_rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(1, A_DIR, r); check("R1 dir", r, MASK);
        rd(1, A_DAT, r); check("R1 data", r, 8'h00);
        rd(1, A_INV, r); check("R1 inv", r, 8'h00);
        rd(1, A_EN, r);  check("R1 enable", r, 8'h00);
        rd(1, A_GLB, r); check("R1 mode", r, 8'h00);
        check("R1 oe", 8'(pin_oe), 8'h00);

        // R10 unbacked bits
        wr(1, A_INV, 8'hFF); rd(1, A_INV, r); check("R10 inv upper", r, MASK);
        wr(1, A_DAT, 8'hE0); wr(1, A_DIR, 8'h00); rd(1, A_DAT, r); check("R10 data upper", r, 8'h00);
        wr(1, A_INV, 8'h00); wr(1, A_DIR, 8'hFF); rd(1, A_DIR, r); check("R10 dir upper", r, MASK);

        // R2 deselected writes and reads
        wr(0, A_DIR, 8'h00); rd(1, A_DIR, r); check("R2 desel write", r, MASK);
        rd(0, A_DIR, r); check("R2 desel read", r, 8'h00);
        wr(1, A_EN, 8'hFF); rd(1, A_EN, r); check("R2 enable bit only", r, 8'h01);
        wr(0, A_EN, 8'h00); rd(1, A_EN, r); check("R2 desel enable", r, 8'h01);
        rd(1, 8'hE3, r); check("R2 unmapped", r, 8'h00);

        // R3 global bit reachable while deselected
        wr(0, A_GLB, 8'hFF); rd(0, A_GLB, r); check("R3 mode bit only", r, 8'h04);
        wr(0, A_GLB, 8'h00); rd(1, A_GLB, r); check("R3 clear", r, 8'h00);

        // R9 synchronizer depth
        wr(1, A_DIR, 8'hFF); wr(1, A_INV, 8'h00);
        pin_in = '0; repeat (4) @(negedge clk);
        dev_sel = 1'b1; reg_addr = A_DAT;
        pin_in = 5'h16;
        @(negedge clk); #1 check("R9 after one edge", reg_rdata, 8'h00);
        @(negedge clk); #1 check("R9 after two edges", reg_rdata, 8'h16);

        // R4-R8 sweep over enable, mode and every direction value
        for (int pp = 0; pp < 2; pp++) begin
            for (int en = 0; en < 2; en++) begin
                wr(0, A_GLB, pp[0] ? 8'h04 : 8'h00);
                wr(1, A_EN, {7'b0, en[0]});
                for (int v = 0; v < 32; v++) begin
                    logic [7:0] dv, dd, di, dp, lvl, eoe, eout, erd;
                    dv = 8'(v) & MASK;
                    dd = 8'((v * 7) ^ 8'h15) & MASK;
                    di = 8'(v * 3 + 9) & MASK;
                    dp = 8'((v * 11) ^ 8'h0A) & MASK;
                    wr(1, A_DIR, dv); wr(1, A_DAT, dd); wr(1, A_INV, di);
                    pin_in = dp[NP-1:0];
                    repeat (3) @(negedge clk);
                    lvl  = dd ^ di;
                    eout = pp[0] ? lvl : 8'h00;
                    eoe  = en[0] ? (~dv & MASK & (pp[0] ? 8'hFF : ~lvl)) : 8'h00;
                    erd  = ((dv & (dp ^ di)) | (~dv & dd)) & MASK;
                    check(pp[0] ? "R6 pin_out" : "R7 pin_out", 8'(pin_out), eout);
                    check(en[0] ? "R4 pin_oe" : "R5 pin_oe", 8'(pin_oe), eoe);
                    rd(1, A_DAT, r); check("R8 data read", r, erd);
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule